// File: doc/BRIEF.md
# Sixteen-Channel Peripheral DMA Controller

This block moves bytes between memory-mapped locations on behalf of sixteen peripheral channels, one transfer at a time. Software selects a channel, loads that channel's descriptor (source address, destination address, beat count and two increment flags), and sets the channel's enable bit. When the peripheral then raises its request, the controller takes the bus, holds the CPU off, and copies the requested number of bytes. Each byte takes one read cycle followed by one write cycle.

A transfer ends in one of two ways. It can run out of beats, which records a completion flag and raises the interrupt. It can also be cut short by the peripheral's stop line, which records a separate stop flag. In both cases the channel's enable bit drops by itself. All control and status is reached through a byte-wide register bank. The sixteen stop flags share one byte address, and a bank bit in the channel-select register decides which eight of them that address reaches.

Top module: `dma16_ctrl`

## Requirements
- R1: A channel starts only when its enable bit is 1 and its `per_req` line is high. Only one transfer runs at a time. When several channels are pending in the same idle cycle, the lowest channel number is served first, and the others wait until it ends.
- R2: `cpu_hold` is high in every cycle of an active transfer and low when the controller is idle. `mem_re` and `mem_we` are only ever high while `cpu_hold` is high.
- R3: Each beat is one `mem_re` cycle at the current source address, with `mem_rdata` sampled in that same cycle. It is followed by one `mem_we` cycle at the current destination address that writes the byte just read. After each beat the source advances by one if its increment flag is 1 and otherwise stays fixed. The destination follows its own flag in the same way. The two strobes are never high together.
- R4: After the last beat of the loaded count, the channel's completion bit is set and its enable bit is cleared. `irq` is high whenever any completion bit is set, and a completion bit can only become 1 through a finished transfer.
- R5: A high `per_stop` bit for the channel being served ends the transfer in that same cycle, with no bus strobe in that cycle. It sets the channel's stop bit, clears its enable bit and leaves its completion bit at 0. A `per_stop` bit for a channel that is not being served has no effect.
- R6: The channel-select register at 0x9B holds the channel number in bits 3:0 and the stop bank bit in bit 7. Bits 6:4 always read as 0.
- R7: The stop-status byte at 0xA4 reaches stop bits 7..0 when the bank bit is 0 and stop bits 15..8 when it is 1. This applies to both reads and writes, and bit n of the byte maps to channel (8×bank + n).
- R8: The enable bits for channels 7..0 sit at 0xAC and those for channels 15..8 at 0xAD. The completion bits for channels 7..0 sit at 0x9C and those for 15..8 at 0x9D. In each byte, bit n maps to the n-th channel of that half. All registers read 0x00 after reset, and any other address reads 0x00.
- R9: Writing 0 to a completion or stop bit clears it, and writing 1 leaves it unchanged. If a hardware set and a software clear of the same bit fall in the same cycle, the bit ends up 1.
- R10: A `desc_we` pulse stores the descriptor inputs into the channel named by bits 3:0 of the select register. A count of 0 runs 65536 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| desc_we | input | 1 | Store the descriptor inputs into the selected channel |
| desc_src | input | 24 | Descriptor source address |
| desc_dst | input | 24 | Descriptor destination address |
| desc_cnt | input | 16 | Descriptor beat count (0 means 65536) |
| desc_src_inc | input | 1 | Source address increments after each beat |
| desc_dst_inc | input | 1 | Destination address increments after each beat |
| per_req | input | 16 | Per-channel transfer request |
| per_stop | input | 16 | Per-channel stop request |
| mem_addr | output | 24 | Bus address |
| mem_re | output | 1 | Bus read strobe |
| mem_we | output | 1 | Bus write strobe |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid in the `mem_re` cycle |
| cpu_hold | output | 1 | CPU stall while a transfer is active |
| irq | output | 1 | Termination interrupt |

## Verification
Two events can land on the same completion bit in one cycle: the hardware setting it as a transfer finishes, and software writing zero to the byte that holds it. The bench waits for the single write beat of a one-beat transfer and issues the clearing write in that cycle. The bit must read back as 1 afterwards, and a later clearing write with no transfer running must take it to 0. A second case is also covered: two channels raise their requests in the same cycle, and the order of the destination writes shows which channel was served first.

// File: rtl/dma16_ctrl.sv
module dma16_ctrl #(
  parameter int AW = 24,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    reg_addr,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          desc_we,
  input  logic [AW-1:0] desc_src,
  input  logic [AW-1:0] desc_dst,
  input  logic [CW-1:0] desc_cnt,
  input  logic          desc_src_inc,
  input  logic          desc_dst_inc,
  input  logic [15:0]   per_req,
  input  logic [15:0]   per_stop,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          cpu_hold,
  output logic          irq
);
  localparam int NCH = 16;
  localparam int CHW = $clog2(NCH);
  localparam logic [7:0] A_CSEL = 8'h9B;
  localparam logic [7:0] A_DNL  = 8'h9C;
  localparam logic [7:0] A_DNH  = 8'h9D;
  localparam logic [7:0] A_STS  = 8'hA4;
  localparam logic [7:0] A_ENL  = 8'hAC;
  localparam logic [7:0] A_ENH  = 8'hAD;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t            st_q;
  logic [CHW-1:0] act_q, pick;
  logic [AW-1:0]  src_q, dst_q;
  logic [CW:0]    rem_q;
  logic           si_q, di_q;
  logic [DW-1:0]  buf_q;
  logic [NCH-1:0] en_q, done_q, stop_q, en_d, done_d, stop_d;
  logic [NCH-1:0] pend, set_done, set_stop;
  logic [7:0]     csel_q;
  logic           stop_now, last_beat;

  logic [AW-1:0]  d_src [NCH];
  logic [AW-1:0]  d_dst [NCH];
  logic [CW-1:0]  d_cnt [NCH];
  logic [NCH-1:0] d_si, d_di;

  assign pend = en_q & per_req;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) pick = CHW'(i);
  end

  assign stop_now  = (st_q != S_IDLE) && per_stop[act_q];
  assign last_beat = (st_q == S_WR) && !stop_now && (rem_q == (CW+1)'(1));
  assign set_done  = last_beat ? (NCH'(1) << act_q) : '0;
  assign set_stop  = stop_now  ? (NCH'(1) << act_q) : '0;

  assign cpu_hold  = (st_q != S_IDLE);
  assign mem_re    = (st_q == S_RD) && !stop_now;
  assign mem_we    = (st_q == S_WR) && !stop_now;
  assign mem_addr  = (st_q == S_WR) ? dst_q : src_q;
  assign mem_wdata = buf_q;
  assign irq       = |done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      act_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
      si_q  <= 1'b0;
      di_q  <= 1'b0;
      buf_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (|pend) begin
          st_q  <= S_RD;
          act_q <= pick;
          src_q <= d_src[pick];
          dst_q <= d_dst[pick];
          si_q  <= d_si[pick];
          di_q  <= d_di[pick];
          rem_q <= (d_cnt[pick] == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, d_cnt[pick]};
        end
        S_RD: if (stop_now) st_q <= S_IDLE;
              else begin
                buf_q <= mem_rdata;
                st_q  <= S_WR;
              end
        S_WR: if (stop_now || last_beat) st_q <= S_IDLE;
              else begin
                st_q  <= S_RD;
                src_q <= src_q + AW'(si_q);
                dst_q <= dst_q + AW'(di_q);
                rem_q <= rem_q - (CW+1)'(1);
              end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    en_d   = en_q;
    done_d = done_q;
    stop_d = stop_q;
    if (reg_we) begin
      case (reg_addr)
        A_ENL: en_d[7:0]   = reg_wdata;
        A_ENH: en_d[15:8]  = reg_wdata;
        A_DNL: done_d[7:0] = done_q[7:0] & reg_wdata;
        A_DNH: done_d[15:8] = done_q[15:8] & reg_wdata;
        A_STS: if (csel_q[7]) stop_d[15:8] = stop_q[15:8] & reg_wdata;
               else           stop_d[7:0]  = stop_q[7:0] & reg_wdata;
        default: ;
      endcase
    end
    en_d   = en_d & ~(set_done | set_stop);
    done_d = done_d | set_done;
    stop_d = stop_d | set_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      done_q <= '0;
      stop_q <= '0;
      csel_q <= '0;
    end else begin
      en_q   <= en_d;
      done_q <= done_d;
      stop_q <= stop_d;
      if (reg_we && reg_addr == A_CSEL)
        csel_q <= {reg_wdata[7], 3'b000, reg_wdata[3:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        d_src[i] <= '0;
        d_dst[i] <= '0;
        d_cnt[i] <= '0;
      end
      d_si <= '0;
      d_di <= '0;
    end else if (desc_we) begin
      d_src[csel_q[CHW-1:0]] <= desc_src;
      d_dst[csel_q[CHW-1:0]] <= desc_dst;
      d_cnt[csel_q[CHW-1:0]] <= desc_cnt;
      d_si[csel_q[CHW-1:0]]  <= desc_src_inc;
      d_di[csel_q[CHW-1:0]]  <= desc_dst_inc;
    end
  end

  always_comb begin
    case (reg_addr)
      A_ENL:   reg_rdata = en_q[7:0];
      A_ENH:   reg_rdata = en_q[15:8];
      A_DNL:   reg_rdata = done_q[7:0];
      A_DNH:   reg_rdata = done_q[15:8];
      A_STS:   reg_rdata = csel_q[7] ? stop_q[15:8] : stop_q[7:0];
      A_CSEL:  reg_rdata = csel_q;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dma16_ctrl_chk.sv
module dma16_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_hold,
  input logic        mem_re,
  input logic        mem_we,
  input logic        irq,
  input logic [15:0] per_stop,
  input logic [3:0]  act,
  input logic [15:0] en,
  input logic [15:0] stop_st,
  input logic [7:0]  reg_addr,
  input logic [7:0]  reg_rdata
);
  // R2
  hold_during_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> cpu_hold);

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  // R5
  stop_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && per_stop[act]) |-> (!mem_re && !mem_we));

  // R5
  stop_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && per_stop[act]) |=> (stop_st[$past(act)] && !en[$past(act)] && !cpu_hold));

  // R4
  done_from_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cpu_hold));

  // R4
  end_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> !en[$past(act)]);

  // R6
  csel_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h9B) |-> (reg_rdata[6:4] == 3'b000));
endmodule

bind dma16_ctrl dma16_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_hold  (cpu_hold),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .irq       (irq),
  .per_stop  (per_stop),
  .act       (act_q),
  .en        (en_q),
  .stop_st   (stop_q),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/tb_dma16_ctrl.sv
`timescale 1ns/1ps
module tb_dma16_ctrl;
  localparam logic [7:0] A_CSEL = 8'h9B, A_DNL = 8'h9C, A_DNH = 8'h9D;
  localparam logic [7:0] A_STS = 8'hA4, A_ENL = 8'hAC, A_ENH = 8'hAD;

  typedef struct packed {
    logic [3:0]  ch;
    logic [7:0]  src;
    logic [7:0]  dst;
    logic [15:0] cnt;
    logic        si;
    logic        di;
    logic [7:0]  stop_at;
    logic [15:0] beats;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{4'd3,  8'h10, 8'h80, 16'd4, 1'b1, 1'b1, 8'd0, 16'd4},
    '{4'd9,  8'h20, 8'h90, 16'd3, 1'b0, 1'b1, 8'd0, 16'd3},
    '{4'd15, 8'h30, 8'hA0, 16'd5, 1'b1, 1'b0, 8'd0, 16'd5},
    '{4'd0,  8'hF0, 8'h08, 16'd1, 1'b1, 1'b1, 8'd0, 16'd1},
    '{4'd5,  8'h40, 8'hB0, 16'd8, 1'b1, 1'b1, 8'd3, 16'd3},
    '{4'd12, 8'h60, 8'hC0, 16'd6, 1'b1, 1'b1, 8'd2, 16'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        reg_we = 1'b0;
  logic        desc_we = 1'b0;
  logic [23:0] desc_src = '0, desc_dst = '0;
  logic [15:0] desc_cnt = '0;
  logic        desc_src_inc = 1'b0, desc_dst_inc = 1'b0;
  logic [15:0] per_req = '0, per_stop = '0;
  logic [23:0] mem_addr;
  logic        mem_re, mem_we, cpu_hold, irq;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] en_m = '0;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  dma16_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_we(desc_we), .desc_src(desc_src), .desc_dst(desc_dst), .desc_cnt(desc_cnt),
    .desc_src_inc(desc_src_inc), .desc_dst_inc(desc_dst_inc),
    .per_req(per_req), .per_stop(per_stop),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cpu_hold(cpu_hold), .irq(irq)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic load_desc(input int ch, input logic [23:0] s, input logic [23:0] d,
                           input logic [15:0] c, input bit si, input bit di);
    reg_wr(A_CSEL, {4'b0000, 4'(ch)});
    desc_src = s; desc_dst = d; desc_cnt = c; desc_src_inc = si; desc_dst_inc = di;
    desc_we = 1'b1;
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic run_xfer(input int ch, input logic [23:0] s, input logic [23:0] d,
                          input logic [15:0] c, input bit si, input bit di,
                          input int stop_at, output int beats, output int bad);
    int guard;
    bit seen;
    logic [23:0] ea;
    logic [7:0] ed;
    load_desc(ch, s, d, c, si, di);
    en_m[ch] = 1'b1;
    reg_wr(A_ENL, en_m[7:0]);
    reg_wr(A_ENH, en_m[15:8]);
    beats = 0; bad = 0; seen = 1'b0; guard = 0;
    per_req[ch] = 1'b1;
    while (guard < 140000) begin
      @(negedge clk);
      guard++;
      if (cpu_hold) seen = 1'b1;
      if (mem_we) begin
        ea = d + (di ? 24'(beats) : 24'd0);
        ed = 8'(s + (si ? 24'(beats) : 24'd0)) ^ 8'hA5;
        if (mem_addr !== ea || mem_wdata !== ed) bad++;
        beats++;
      end
      if (stop_at != 0 && beats == stop_at && mem_re) per_stop[ch] = 1'b1;
      if (seen && !cpu_hold) break;
    end
    per_req[ch] = 1'b0;
    per_stop[ch] = 1'b0;
    en_m[ch] = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R2 watchdog: actual=190000 cycles expected=<190000");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd, rd2, dbyte;
    logic [7:0] wa [4];
    int b, bad, nw, guard;
    bit stopped;
    vec_t v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    reg_rd(A_ENL, rd);  chk("R8", "enable lo after reset", rd, 8'h00);
    reg_rd(A_ENH, rd);  chk("R8", "enable hi after reset", rd, 8'h00);
    reg_rd(A_DNL, rd);  chk("R8", "done lo after reset", rd, 8'h00);
    reg_rd(A_DNH, rd);  chk("R8", "done hi after reset", rd, 8'h00);
    reg_rd(A_STS, rd);  chk("R8", "stop after reset", rd, 8'h00);
    reg_rd(A_CSEL, rd); chk("R8", "select after reset", rd, 8'h00);
    chk("R2", "hold after reset", {cpu_hold, mem_re, mem_we, irq}, 4'b0000);

    // R6 reserved bits
    reg_wr(A_CSEL, 8'hFF); reg_rd(A_CSEL, rd);
    chk("R6", "select reserved bits", rd, 8'h8F);
    reg_wr(A_CSEL, 8'h00);
    reg_wr(8'h50, 8'hFF); reg_rd(8'h50, rd);
    chk("R8", "unmapped read", rd, 8'h00);

    // R3 R4 R5 R7 R9 table of transfers
    for (int i = 0; i < 6; i++) begin
      v = TBL[i];
      run_xfer(int'(v.ch), {16'h0000, v.src}, {16'h0000, v.dst}, v.cnt, v.si, v.di,
               int'(v.stop_at), b, bad);
      stopped = (v.stop_at != 8'd0);
      chk(stopped ? "R5" : "R3", "beat count", b, 32'(v.beats));
      chk("R3", "beat address/data mismatches", bad, 0);
      dbyte = v.ch[3] ? A_DNH : A_DNL;
      reg_rd(dbyte, rd);
      chk(stopped ? "R5" : "R4", "done byte", rd, stopped ? 8'h00 : (8'h01 << v.ch[2:0]));
      chk("R4", "irq level", irq, !stopped);
      reg_wr(dbyte, 8'hFF); reg_rd(dbyte, rd);
      chk("R9", "done after writing ones", rd, stopped ? 8'h00 : (8'h01 << v.ch[2:0]));
      reg_wr(A_CSEL, {v.ch[3], 3'b000, v.ch}); reg_rd(A_STS, rd);
      chk("R7", "stop byte selected bank", rd, stopped ? (8'h01 << v.ch[2:0]) : 8'h00);
      reg_wr(A_CSEL, {~v.ch[3], 3'b000, v.ch}); reg_rd(A_STS, rd);
      chk("R7", "stop byte other bank", rd, 8'h00);
      reg_rd(A_ENL, rd); reg_rd(A_ENH, rd2);
      chk(stopped ? "R5" : "R4", "enable cleared", {rd2, rd}, 16'h0000);
      reg_wr(dbyte, 8'h00);
      reg_wr(A_CSEL, {v.ch[3], 3'b000, v.ch});
      reg_wr(A_STS, 8'h00);
      reg_rd(dbyte, rd); chk("R9", "done cleared by zero", rd, 8'h00);
      reg_rd(A_STS, rd); chk("R9", "stop cleared by zero", rd, 8'h00);
    end

    // R1 simultaneous requests, lowest channel first
    load_desc(2, 24'h000050, 24'h000040, 16'd2, 1'b1, 1'b1);
    load_desc(6, 24'h000070, 24'h000060, 16'd2, 1'b1, 1'b1);
    en_m = 16'h0044;
    reg_wr(A_ENL, 8'h44); reg_wr(A_ENH, 8'h00);
    @(negedge clk);
    per_req[2] = 1'b1; per_req[6] = 1'b1;
    nw = 0; guard = 0;
    while (nw < 4 && guard < 100) begin
      @(negedge clk);
      guard++;
      if (mem_we) begin wa[nw] = mem_addr[7:0]; nw++; end
    end
    @(negedge clk);
    per_req = '0; en_m = '0;
    chk("R1", "first write (channel 2)", wa[0], 8'h40);
    chk("R1", "second write (channel 2)", wa[1], 8'h41);
    chk("R1", "third write (channel 6)", wa[2], 8'h60);
    chk("R1", "fourth write (channel 6)", wa[3], 8'h61);
    chk("R2", "hold released", cpu_hold, 1'b0);
    reg_rd(A_DNL, rd); chk("R1", "both done bits", rd, 8'h44);
    reg_wr(A_DNL, 8'h00);

    // R9 hardware set and software clear in the same cycle
    load_desc(1, 24'h000010, 24'h000020, 16'd1, 1'b1, 1'b1);
    en_m = 16'h0002;
    reg_wr(A_ENL, 8'h02); reg_wr(A_ENH, 8'h00);
    @(negedge clk);
    per_req[1] = 1'b1;
    guard = 0;
    while (!mem_we && guard < 20) begin @(negedge clk); guard++; end
    reg_addr = A_DNL; reg_wdata = 8'h00; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; per_req[1] = 1'b0; en_m = '0;
    reg_rd(A_DNL, rd); chk("R9", "hardware set wins over clear", rd, 8'h02);
    reg_wr(A_DNL, 8'h00);
    reg_rd(A_DNL, rd); chk("R9", "later clear takes effect", rd, 8'h00);

    // R5 stop on idle channels has no effect
    @(negedge clk);
    per_stop = 16'hFFFF;
    repeat (3) @(negedge clk);
    per_stop = '0;
    chk("R5", "hold while idle stop", cpu_hold, 1'b0);
    reg_wr(A_CSEL, 8'h00); reg_rd(A_STS, rd); chk("R5", "idle stop lo bank", rd, 8'h00);
    reg_wr(A_CSEL, 8'h80); reg_rd(A_STS, rd); chk("R5", "idle stop hi bank", rd, 8'h00);
    reg_wr(A_CSEL, 8'h00);

    // R10 count zero means 65536 beats
    run_xfer(7, 24'h000000, 24'h000100, 16'd0, 1'b0, 1'b0, 0, b, bad);
    chk("R10", "beats for count 0", b, 65536);
    chk("R10", "fixed address mismatches", bad, 0);
    reg_rd(A_DNL, rd); chk("R10", "done after count 0", rd, 8'h80);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule